// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is a bus-programmed serial port for the common four-wire SPI framing. Software configures it through a small register bank: a format word, a control word, a prescale register, a data register and a status register. It then paces each transfer by polling the status bits. Words written to the data register queue in an eight-entry transmit FIFO. Received words collect in an eight-entry receive FIFO, and software reads them back from the same data address.

As a master, the port generates the serial clock and drives the select line low for each frame. The serial clock is the system clock divided by an even prescale value and then by a per-frame divide field held in the format word. As a slave, the port oversamples the external clock, select and data pins through synchronizers and shifts only while select is low. Frame length ranges from 4 to 16 bits, and all four polarity/phase combinations are supported. The port also offers an internal loopback path and a switch that keeps the slave from driving its output pin.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset, status reads 0x0002, a data read returns 0, ssel_o is high and sclk_o is low.
- R2: The registers sit at word addresses 0 (format), 1 (control), 2 (data), 3 (status) and 4 (prescale). The format, control and prescale registers read back what was written, subject to R5.
- R3: Format bits 3:0 hold frame length minus one (legal lengths 4..16). Words are sent MSB first. A received word is right-aligned, with all bits above the frame length read as zero.
- R4: Format bit 6 is the idle level of the serial clock. Format bit 7 selects the sampling edge: 0 samples on the leading (first) clock edge of each bit, and 1 samples on the trailing edge.
- R5: A master serial clock half-period lasts (P/2)*(D+1) system clocks, where P is the prescale register and D is format bits 15:8. Bit 0 of a prescale write is forced to 0, and a resulting value of 0 is stored as 2.
- R6: In master mode, ssel_o goes low one half-period before the first clock edge, stays low through the frame, and is high otherwise.
- R7: Control bit 0 (loopback) routes the transmitted bit to the receive shifter, and the miso_i pin is ignored.
- R8: Control bit 1 enables the port. No frame starts while the port is disabled, or while format bits 5:4 are nonzero.
- R9: Control bit 2 selects slave mode. A slave shifts only while ssel_i is low. miso_oe is high only in slave mode with select low and control bit 3 (output disable) clear.
- R10: Status bit 1 means the transmit FIFO is not full. Status bit 2 means the receive FIFO is not empty. Status bit 4 (busy) means a frame is in progress or transmit data is waiting. All other status bits read 0.
- R11: Each FIFO holds 8 words. A data write to a full transmit FIFO is dropped, and a data read from an empty receive FIFO returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive FIFO at data address) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ssel_o | output | 1 | Select driven in master mode, active low |
| ssel_i | input | 1 | Select received in slave mode, active low |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Master data in |

## Verification
The assertions take for granted that the format, control and prescale registers are only rewritten while the port is disabled or idle, and that the frame length is legal. They also assume the external slave clock's half-period spans several system clocks, so the synchronizers see every edge. The stimulus drops the enable bit before each reconfiguration and uses lengths 4 to 16 only. It drives the slave pins from the bench with an eight-cycle half-period and changes them on the falling system clock edge.

// File: rtl/sspc_pkg.sv
package sspc_pkg;
    localparam int WORD_W = 16;
    localparam int A_FMT  = 0;
    localparam int A_CTL  = 1;
    localparam int A_DATA = 2;
    localparam int A_STAT = 3;
    localparam int A_PRE  = 4;

    // format word: div[15:8] phase[7] pol[6] kind[5:4] len_m1[3:0]
    typedef struct packed {
        logic [7:0] div;
        logic       phase;
        logic       pol;
        logic [1:0] kind;
        logic [3:0] len_m1;
    } fmt_t;

    // control word: out_dis[3] slave[2] enable[1] loop[0]
    typedef struct packed {
        logic out_dis;
        logic slave;
        logic enable;
        logic loop;
    } ctl_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_TAIL} eng_st_e;

    typedef struct packed {
        eng_st_e     st;
        logic [15:0] cnt;
        logic [5:0]  edge_n;
        logic [15:0] txw;
        logic [15:0] rxw;
        logic        sclk;
        logic        ssel;
        logic [2:0]  s_sclk;
        logic [2:0]  s_ssel;
        logic [1:0]  s_mosi;
    } eng_t;
endpackage

// File: rtl/sspc_fifo.sv
module sspc_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem_q[q.rp];

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wp] <= din;
    end

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (AW+1)'(DEPTH));

    // R11
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(q.wp)));
endmodule

// File: rtl/sspc_engine.sv
module sspc_engine
    import sspc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fmt_t        fmt,
    input  ctl_t        ctl,
    input  logic [7:0]  prescale,
    input  logic        tx_avail,
    input  logic [15:0] tx_word,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [15:0] rx_word,
    output logic        active,
    input  logic        sclk_i,
    input  logic        ssel_i,
    input  logic        mosi_i,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        ssel_o,
    output logic        mosi_o,
    output logic        miso_o,
    output logic        miso_oe
);
    eng_t q, d;

    logic        master_en, slave_en;
    logic [15:0] half;
    logic        tick;
    logic [4:0]  flen;
    logic [5:0]  last_edge;
    logic [15:0] mask;
    logic        lead, samp, shft, rx_in, sel, sedge;

    assign master_en = ctl.enable && !ctl.slave && (fmt.kind == 2'b00);
    assign slave_en  = ctl.enable &&  ctl.slave && (fmt.kind == 2'b00);
    assign half      = {9'd0, prescale[7:1]} * ({8'd0, fmt.div} + 16'd1);
    assign tick      = (q.cnt == half - 16'd1);
    assign flen      = {1'b0, fmt.len_m1} + 5'd1;
    assign last_edge = {flen, 1'b0} - 6'd1;
    assign mask      = 16'((32'd1 << flen) - 32'd1);

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        lead    = 1'b0;
        samp    = 1'b0;
        shft    = 1'b0;
        rx_in   = 1'b0;
        sel     = 1'b0;
        sedge   = 1'b0;
        d.s_sclk = {q.s_sclk[1:0], sclk_i};
        d.s_ssel = {q.s_ssel[1:0], ssel_i};
        d.s_mosi = {q.s_mosi[0], mosi_i};
        if (master_en) begin
            rx_in = ctl.loop ? q.txw[fmt.len_m1] : miso_i;
            unique case (q.st)
                ENG_IDLE: begin
                    d.sclk = fmt.pol;
                    d.ssel = 1'b1;
                    if (tx_avail) begin
                        tx_pop   = 1'b1;
                        d.txw    = tx_word;
                        d.rxw    = '0;
                        d.edge_n = '0;
                        d.cnt    = '0;
                        d.ssel   = 1'b0;
                        d.st     = ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (tick) begin
                        d.cnt  = '0;
                        d.sclk = ~q.sclk;
                        lead   = ~q.edge_n[0];
                        samp   = lead ^ fmt.phase;
                        shft   = !samp && !(fmt.phase && q.edge_n == '0);
                        if (samp) d.rxw = {q.rxw[14:0], rx_in};
                        if (shft) d.txw = q.txw << 1;
                        if (q.edge_n == last_edge) d.st = ENG_TAIL;
                        else d.edge_n = q.edge_n + 6'd1;
                    end else begin
                        d.cnt = q.cnt + 16'd1;
                    end
                end
                ENG_TAIL: begin
                    if (tick) begin
                        rx_push = 1'b1;
                        d.ssel  = 1'b1;
                        d.st    = ENG_IDLE;
                    end else begin
                        d.cnt = q.cnt + 16'd1;
                    end
                end
                default: d.st = ENG_IDLE;
            endcase
        end else if (slave_en) begin
            d.sclk = fmt.pol;
            d.ssel = 1'b1;
            rx_in  = ctl.loop ? q.txw[fmt.len_m1] : q.s_mosi[1];
            sel    = !q.s_ssel[1];
            sedge  = q.s_sclk[2] ^ q.s_sclk[1];
            if (q.st == ENG_IDLE) begin
                if (sel) begin
                    tx_pop   = tx_avail;
                    d.txw    = tx_avail ? tx_word : '0;
                    d.rxw    = '0;
                    d.edge_n = '0;
                    d.st     = ENG_RUN;
                end
            end else if (!sel) begin
                d.st = ENG_IDLE;
            end else if (sedge) begin
                lead = (q.s_sclk[2] == fmt.pol);
                samp = lead ^ fmt.phase;
                shft = !samp && !(fmt.phase && q.edge_n == '0);
                if (samp) d.rxw = {q.rxw[14:0], rx_in};
                if (shft) d.txw = q.txw << 1;
                if (q.edge_n == last_edge) begin
                    rx_push = 1'b1;
                    d.st    = ENG_IDLE;
                end else begin
                    d.edge_n = q.edge_n + 6'd1;
                end
            end
        end else begin
            d.st   = ENG_IDLE;
            d.sclk = fmt.pol;
            d.ssel = 1'b1;
        end
        rx_word = d.rxw & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ENG_IDLE;
            q.ssel   <= 1'b1;
            q.s_ssel <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign sclk_o  = q.sclk;
    assign ssel_o  = q.ssel;
    assign active  = (q.st != ENG_IDLE);
    assign mosi_o  = (master_en && q.st != ENG_IDLE) ? q.txw[fmt.len_m1] : 1'b0;
    assign miso_o  = slave_en ? q.txw[fmt.len_m1] : 1'b0;
    assign miso_oe = slave_en && !ctl.out_dis && !q.s_ssel[1];

    // R6
    master_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && q.st != ENG_IDLE) |-> !ssel_o);

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $rose(ssel_o)) |-> (sclk_o == fmt.pol));

    // R9
    slave_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && rx_push) |-> !q.s_ssel[1]);
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
    import sspc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              ssel_o,
    input  logic              ssel_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i
);
    typedef struct packed {
        fmt_t       fmt;
        ctl_t       ctl;
        logic [7:0] pre;
    } regs_t;

    regs_t q, d;

    logic        tx_push, tx_pop, tx_empty, tx_full;
    logic [15:0] tx_dout;
    logic        rx_push, rx_pop, rx_empty, rx_full;
    logic [15:0] rx_din, rx_dout;
    logic        eng_active, busy;
    logic [7:0]  pre_even;

    assign pre_even = {wdata[7:1], 1'b0};
    assign tx_push  = wr_en && (addr == ADDR_W'(A_DATA));
    assign rx_pop   = rd_en && (addr == ADDR_W'(A_DATA));
    assign busy     = eng_active || !tx_empty;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                ADDR_W'(A_FMT): d.fmt = fmt_t'(wdata);
                ADDR_W'(A_CTL): d.ctl = ctl_t'(wdata[3:0]);
                ADDR_W'(A_PRE): d.pre = (pre_even == 8'd0) ? 8'd2 : pre_even;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pre <= 8'd2;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(A_FMT):  rdata = q.fmt;
            ADDR_W'(A_CTL):  rdata = {12'd0, q.ctl};
            ADDR_W'(A_DATA): rdata = rx_dout;
            ADDR_W'(A_STAT): rdata = {11'd0, busy, 1'b0, !rx_empty, !tx_full, 1'b0};
            ADDR_W'(A_PRE):  rdata = {8'd0, q.pre};
            default:         rdata = '0;
        endcase
    end

    sspc_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata), .pop(tx_pop),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full));

    sspc_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full));

    sspc_engine u_eng (
        .clk(clk), .rst_n(rst_n), .fmt(q.fmt), .ctl(q.ctl), .prescale(q.pre),
        .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_din), .active(eng_active),
        .sclk_i(sclk_i), .ssel_i(ssel_i), .mosi_i(mosi_i), .miso_i(miso_i),
        .sclk_o(sclk_o), .ssel_o(ssel_o), .mosi_o(mosi_o), .miso_o(miso_o),
        .miso_oe(miso_oe));

    // R8
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> eng_active);

    // R5
    prescale_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pre[0] == 1'b0) && (q.pre != 8'd0));

    // R11
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> rx_full);
endmodule

// File: tb/sim_serial_port_ctrl.sv
module sim_serial_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SH = 8;

    logic clk = 0, rst_n = 0;
    logic [2:0] addr = 0;
    logic wr_en = 0, rd_en = 0;
    logic [15:0] wdata = 0, rdata;
    logic sclk_o, ssel_o, mosi_o, miso_o, miso_oe;
    logic sclk_i = 0, ssel_i = 1, mosi_i = 0, miso_i = 0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic m_cpol = 0, m_cpha = 0, m_idle = 0;
    int m_size = 8, m_idx = 0, m_edges = 0;
    logic [15:0] m_pat = 0, m_cap = 0;
    int t_last = 0, iv_min = 0, iv_max = 0;
    logic prev_sclk = 0, prev_ssel = 1;

    serial_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .sclk_o(sclk_o), .sclk_i(sclk_i),
        .ssel_o(ssel_o), .ssel_i(ssel_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side slave that answers the master
    always @(negedge clk) begin
        if (ssel_o) miso_i = m_idle;
        if (prev_ssel && !ssel_o) begin
            m_idx = 0; m_edges = 0; m_cap = 0; t_last = cyc;
            miso_i = m_pat[m_size-1];
        end else if (!ssel_o && sclk_o != prev_sclk) begin
            if (cyc - t_last < iv_min) iv_min = cyc - t_last;
            if (cyc - t_last > iv_max) iv_max = cyc - t_last;
            t_last = cyc;
            if ((prev_sclk == m_cpol) ^ m_cpha) m_cap = {m_cap[14:0], mosi_o};
            else if (!(m_cpha && m_edges == 0)) begin
                m_idx++;
                miso_i = (m_idx < m_size) ? m_pat[m_size-1-m_idx] : 1'b0;
            end
            m_edges++;
        end
        prev_sclk = sclk_o;
        prev_ssel = ssel_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int k = 0; k < 5000; k++) begin
            rd(3, s);
            if (!s[4]) break;
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic slave_frame(input logic cpha, input int len, input logic [15:0] pat,
                               output logic [15:0] cap, output logic oe);
        cap = 0;
        ssel_i = 0;
        wait_n(2*SH);
        oe = miso_oe;
        for (int i = len-1; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = pat[i]; wait_n(SH);
                cap = {cap[14:0], miso_o}; sclk_i = ~sclk_i; wait_n(SH);
                sclk_i = ~sclk_i;
            end else begin
                wait_n(SH); sclk_i = ~sclk_i; mosi_i = pat[i]; wait_n(SH);
                cap = {cap[14:0], miso_o}; sclk_i = ~sclk_i;
            end
        end
        wait_n(SH);
        ssel_i = 1;
        wait_n(4);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] v, m, cap;
        logic oe;
        int sizes [3] = '{5, 8, 13};
        wait_n(4);
        rst_n = 1;
        wait_n(2);
        // R1 reset state
        rd(3, v); chk("R1 status", v, 16'h0002);
        rd(2, v); chk("R1 data", v, 0);
        chk("R1 ssel", ssel_o, 1);
        chk("R1 sclk", sclk_o, 0);
        // R2 readback, R5 prescale rounding
        wr(0, 16'h3A47); rd(0, v); chk("R2 format", v, 16'h3A47);
        wr(1, 16'h0009); rd(1, v); chk("R2 control", v, 16'h0009);
        wr(1, 0);
        wr(4, 16'h0005); rd(4, v); chk("R5 odd prescale", v, 4);
        wr(4, 16'h0001); rd(4, v); chk("R5 prescale one", v, 2);
        wr(4, 16'h0000); rd(4, v); chk("R5 prescale zero", v, 2);
        // R3 R4 R7 loopback sweep over every length and mode
        m_idle = 1;
        for (int len = 4; len <= 16; len++) begin
            for (int md = 0; md < 4; md++) begin
                logic [15:0] p;
                p = 16'hA5C3 ^ 16'(len * 16'h0111) ^ 16'(md * 16'h2002);
                m = 16'((32'd1 << len) - 1);
                wr(1, 0);
                wr(0, {8'd0, md[0], md[1], 2'b00, 4'(len-1)});
                wr(1, 16'h0003);
                wr(2, p);
                wait_idle();
                rd(2, v);
                chk($sformatf("R7 R3 loopback len %0d mode %0d", len, md), v, p & m);
            end
        end
        rd(3, v); chk("R10 drained status", v, 16'h0002);
        // R4 R5 R6 external master transfers
        for (int si = 0; si < 3; si++) begin
            for (int md = 0; md < 4; md++) begin
                logic [15:0] tx;
                int hp;
                tx = 16'h6B3D ^ 16'(sizes[si] << 4);
                m = 16'((32'd1 << sizes[si]) - 1);
                hp = (md + 1) * (md + 1);
                wr(1, 0);
                wr(4, 16'(2 + 2*md));
                wr(0, {8'(md), md[0], md[1], 2'b00, 4'(sizes[si]-1)});
                m_cpol = md[1]; m_cpha = md[0]; m_size = sizes[si];
                m_pat = 16'h9A5E ^ 16'(sizes[si]);
                iv_min = 99999; iv_max = 0;
                wr(1, 16'h0002);
                wait_n(3);
                chk($sformatf("R4 idle level mode %0d", md), sclk_o, md[1]);
                chk("R6 idle select", ssel_o, 1);
                wr(2, tx);
                wait_idle();
                chk($sformatf("R4 mosi len %0d mode %0d", sizes[si], md), m_cap & m, tx & m);
                rd(2, v);
                chk($sformatf("R4 miso len %0d mode %0d", sizes[si], md), v, m_pat & m);
                chk("R5 R6 half period min", iv_min, hp);
                chk("R5 half period max", iv_max, hp);
            end
        end
        // R8 disabled port and non-SPI format start nothing
        wr(1, 0);
        wr(4, 2);
        wr(0, 16'h0007);
        wr(2, 16'h00C5);
        wait_n(60);
        chk("R8 disabled select", ssel_o, 1);
        rd(3, v); chk("R8 R10 disabled busy", v, 16'h0012);
        wr(0, 16'h0017);
        wr(1, 16'h0002);
        wait_n(60);
        chk("R8 bad format select", ssel_o, 1);
        wr(1, 0); wr(0, 16'h0007); wr(1, 16'h0003);
        wait_idle();
        rd(2, v); chk("R8 queued word sent", v, 16'h00C5);
        // R11 fifo depth, drop on full, empty read
        wr(1, 0);
        for (int i = 0; i < 9; i++) wr(2, 16'(8'h10 + i));
        rd(3, v); chk("R10 R11 full status", v, 16'h0010);
        wr(1, 16'h0003);
        wait_idle();
        rd(3, v); chk("R10 rx ready status", v, 16'h0006);
        for (int i = 0; i < 8; i++) begin
            rd(2, v); chk($sformatf("R11 word %0d", i), v, 16'(8'h10 + i));
        end
        rd(2, v); chk("R11 empty read", v, 0);
        // R9 slave transfers
        for (int md = 0; md < 4; md++) begin
            logic [15:0] st, pm;
            st = 16'h00B4 ^ 16'(md * 8'h11);
            pm = 16'h0069 ^ 16'(md * 8'h24);
            wr(1, 0);
            sclk_i = md[1];
            wr(0, {8'd0, md[0], md[1], 2'b00, 4'd7});
            wr(1, 16'h0006);
            wr(2, st);
            wait_n(6);
            chk("R9 oe idle", miso_oe, 0);
            slave_frame(md[0], 8, pm, cap, oe);
            chk($sformatf("R9 slave oe mode %0d", md), oe, 1);
            chk($sformatf("R9 slave miso mode %0d", md), cap & 16'hFF, st & 16'hFF);
            rd(2, v);
            chk($sformatf("R9 slave rx mode %0d", md), v, pm & 16'hFF);
            chk("R9 oe after frame", miso_oe, 0);
        end
        // R9 output disable and deselected clocks
        wr(1, 0); sclk_i = 0;
        wr(0, 16'h0007);
        wr(1, 16'h000E);
        slave_frame(1'b0, 8, 16'h005A, cap, oe);
        chk("R9 output disabled", oe, 0);
        rd(2, v); chk("R9 rx with output disabled", v, 16'h005A);
        for (int i = 0; i < 16; i++) begin
            sclk_i = ~sclk_i; mosi_i = i[0]; wait_n(SH);
        end
        rd(3, v); chk("R9 deselected ignored", v, 16'h0002);
        finish_up();
    end
endmodule